// File: doc/BRIEF.md
# Log-Sine FM Operator Output Stage

This block turns one operator's 10-bit phase and 7-bit attenuation into a signed sample, the way a log-domain FM synthesizer does. The lower nine phase bits address a 256-entry quarter-wave table that holds the negative base-2 logarithm of the sine, scaled by 256. The attenuation is scaled by 16 and added to that value, with saturation. An exponent table and a right shift then turn the summed level back into a linear magnitude. The top phase bit selects the negative half-wave. That half is given as the ones' complement of the magnitude, unless the operator's rectify control forces it to zero.

Each accepted sample also goes into a two-deep history. The sum of the two most recent samples, arithmetically shifted right by a programmable amount, is returned as the self-feedback modulation term for the phase adder upstream. A silence input forces a zero sample, and that zero is also written into the history. Phase accumulation and envelope generation sit outside this block.

Top module: `fm_logsin_op`

## Requirements
- R1: After reset, `sample` is 0, `out_valid` is 0 and `fb_out` is 0.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high for exactly the following cycle and `sample` shows the new result in that cycle. Without `in_valid`, `sample` and `fb_out` hold their values.
- R3: The table index is `phase[7:0]`, bitwise inverted when `phase[8]` is 1. Phases k and 0x1FF-k therefore give the same sample.
- R4: The quarter-wave table entry i is round(-log2(sin((i+0.5)·π/512))·256). The exponent table entry i is round(2^((255-i)/256)·1024). The level is the table entry plus `atten`·16, saturated at 4095. The magnitude is the exponent table entry at `level[7:0]`, shifted right by `level[11:8]`.
- R5: When `phase[9]` is 0, `sample` equals the magnitude, so it is never negative.
- R6: When `phase[9]` is 1 and `rectify` is 0, `sample` is the bitwise complement of the magnitude, that is -(magnitude+1).
- R7: When `phase[9]` is 1 and `rectify` is 1, `sample` is 0. On the positive half-wave, `rectify` has no effect.
- R8: When `silent` is 1, `sample` is 0 and 0 enters the feedback history.
- R9: `fb_out` equals (last sample + the sample before it), arithmetically shifted right by `fb_shift`. A change of `fb_shift` takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Accept the inputs this cycle |
| phase | input | 10 | Operator phase; bit 9 sign, bit 8 mirror |
| atten | input | 7 | Attenuation, 0.375 dB-style log steps ×16 in the level |
| rectify | input | 1 | Zero the negative half-wave |
| silent | input | 1 | Force a zero sample |
| fb_shift | input | 4 | Right-shift applied to the feedback sum |
| out_valid | output | 1 | A new sample is present |
| sample | output | 13 | Signed operator sample |
| fb_out | output | 14 | Signed feedback modulation term |

## Verification
Assertions check on every cycle the behaviour that depends only on control bits:
- the one-cycle strobe timing and the holding of the output between strobes;
- zero output for silence and for a rectified negative half;
- the sign of the output on each half-wave;
- the history shift into the feedback term.

The bench's scenarios cover the numeric content: the table values, the mirrored indexing, the saturation of the attenuation sum and the exact complement codes. For these it compares against a model built from the formulas in R4.

// File: rtl/fm_logsin_op.sv
module fm_logsin_op #(
  parameter int OUT_W   = 13,
  parameter int SHIFT_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [9:0]                phase,
  input  logic [6:0]                atten,
  input  logic                      rectify,
  input  logic                      silent,
  input  logic [SHIFT_W-1:0]        fb_shift,
  output logic                      out_valid,
  output logic signed [OUT_W-1:0]   sample,
  output logic signed [OUT_W:0]     fb_out
);
  localparam int    TBL_N  = 256;
  localparam real   PI     = 3.14159265358979323846;
  localparam int    LVL_W  = 12;
  localparam int    MAG_W  = 11;

  logic [LVL_W-1:0] lsin_rom [TBL_N];
  logic [MAG_W-1:0] exp_rom  [TBL_N];

  initial begin
    for (int i = 0; i < TBL_N; i++) begin
      lsin_rom[i] = LVL_W'($rtoi(-$ln($sin((real'(i) + 0.5) * PI / 512.0)) / $ln(2.0) * 256.0 + 0.5));
      exp_rom[i]  = MAG_W'($rtoi($pow(2.0, real'(255 - i) / 256.0) * 1024.0 + 0.5));
    end
  end

  logic [7:0]        idx;
  logic [LVL_W:0]    lvl_sum;
  logic [LVL_W-1:0]  lvl;
  logic [MAG_W-1:0]  mag;
  logic [OUT_W-1:0]  mag_ext;
  logic signed [OUT_W-1:0] nxt;
  logic signed [OUT_W-1:0] hist1, hist2;
  logic signed [OUT_W:0]   fb_sum;

  assign idx     = phase[8] ? ~phase[7:0] : phase[7:0];
  assign lvl_sum = {1'b0, lsin_rom[idx]} + {2'b00, atten, 4'b0000};
  assign lvl     = lvl_sum[LVL_W] ? {LVL_W{1'b1}} : lvl_sum[LVL_W-1:0];
  assign mag     = exp_rom[lvl[7:0]] >> lvl[11:8];
  assign mag_ext = {{(OUT_W-MAG_W){1'b0}}, mag};
  assign nxt     = (silent || (phase[9] && rectify)) ? '0
                 : phase[9] ? signed'(~mag_ext) : signed'(mag_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sample    <= '0;
      hist1     <= '0;
      hist2     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sample <= nxt;
        hist1  <= nxt;
        hist2  <= hist1;
      end
    end
  end

  assign fb_sum = {hist1[OUT_W-1], hist1} + {hist2[OUT_W-1], hist2};
  assign fb_out = fb_sum >>> fb_shift;

  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(sample));
  p_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && silent) |-> (sample == 0));
  p_rectify_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && phase[9] && rectify) |-> (sample == 0));
  p_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && !silent && phase[9] && !rectify) |-> (sample < 0));
  p_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && !phase[9]) |-> (sample >= 0));
  p_hist_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (hist2 == $past(hist1)));
endmodule

// File: tb/fm_logsin_op_bench.sv
module fm_logsin_op_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [9:0] phase = '0;
  logic [6:0] atten = '0;
  logic rectify = 1'b0;
  logic silent = 1'b0;
  logic [3:0] fb_shift = '0;
  logic out_valid;
  logic signed [12:0] sample;
  logic signed [13:0] fb_out;

  int checks = 0;
  int fails = 0;
  int lsin_m [256];
  int exp_m  [256];
  int mh1 = 0, mh2 = 0;
  int last_exp = 0;

  always #10 clk = ~clk;

  fm_logsin_op u_fm_logsin_op (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .phase(phase),
    .atten(atten), .rectify(rectify), .silent(silent), .fb_shift(fb_shift),
    .out_valid(out_valid), .sample(sample), .fb_out(fb_out)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(int ph, int at, bit rc, bit sl);
    int ix, lv, mg;
    ix = ph[8] ? (~ph & 255) : (ph & 255);
    lv = lsin_m[ix] + at * 16;
    if (lv > 4095) lv = 4095;
    mg = exp_m[lv & 255] >> (lv >> 8);
    if (sl) return 0;
    if (ph[9]) return rc ? 0 : -(mg + 1);
    return mg;
  endfunction

  task automatic issue(string req, int ph, int at, bit rc, bit sl);
    @(negedge clk);
    phase = 10'(ph); atten = 7'(at); rectify = rc; silent = sl; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    last_exp = model(ph, at, rc, sl);
    mh2 = mh1; mh1 = last_exp;
    chk({req, " valid"}, int'(out_valid), 1);
    chk(req, int'(sample), last_exp);
  endtask

  task automatic t_reset;
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 sample", int'(sample), 0);
    chk("R1 fb", int'(fb_out), 0);
  endtask

  task automatic t_positive;
    issue("R5 ph0", 0, 0, 0, 0);
    issue("R5 ph255", 255, 0, 0, 0);
    issue("R4 ph100 at20", 100, 20, 0, 0);
    issue("R4 ph37 at63", 37, 63, 1, 0);
  endtask

  task automatic t_mirror;
    int a;
    issue("R3 ph40", 40, 5, 0, 0);
    a = int'(sample);
    issue("R3 ph471", 511 - 40, 5, 0, 0);
    chk("R3 mirror equal", int'(sample), a);
  endtask

  task automatic t_saturate;
    issue("R4 sat ph0 at127", 0, 127, 0, 0);
    chk("R4 sat zero", int'(sample), 0);
    issue("R4 ph255 at127", 255, 127, 0, 0);
  endtask

  task automatic t_negative;
    issue("R6 ph512", 512, 0, 0, 0);
    issue("R6 ph700 at30", 700, 30, 0, 0);
    issue("R6 sat neg", 512, 127, 0, 0);
    chk("R6 sat neg is -1", int'(sample), -1);
  endtask

  task automatic t_rectify;
    issue("R7 neg rect", 600, 3, 1, 0);
    issue("R7 pos rect", 200, 3, 1, 0);
  endtask

  task automatic t_silent;
    issue("R8 silent", 255, 0, 0, 1);
    issue("R8 silent2", 700, 0, 0, 1);
    fb_shift = 4'd0;
    #1 chk("R8 history zero", int'(fb_out), 0);
  endtask

  task automatic t_feedback;
    issue("R9 a", 255, 0, 0, 0);
    issue("R9 b", 767, 10, 0, 0);
    for (int s = 0; s < 16; s += 3) begin
      fb_shift = 4'(s);
      #1 chk($sformatf("R9 fb shift %0d", s), int'(fb_out), (mh1 + mh2) >>> s);
    end
    issue("R9 c", 300, 0, 0, 0);
    fb_shift = 4'd1;
    #1 chk("R9 fb after c", int'(fb_out), (mh1 + mh2) >>> 1);
  endtask

  task automatic t_hold;
    int s0, f0;
    s0 = int'(sample); f0 = int'(fb_out);
    @(negedge clk);
    phase = 10'd5; atten = 7'd0; silent = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 no valid", int'(out_valid), 0);
    chk("R2 sample hold", int'(sample), s0);
    chk("R2 fb hold", int'(fb_out), f0);
    silent = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      lsin_m[i] = $rtoi(-$ln($sin((real'(i) + 0.5) * 3.14159265358979323846 / 512.0)) / $ln(2.0) * 256.0 + 0.5);
      exp_m[i]  = $rtoi($pow(2.0, real'(255 - i) / 256.0) * 1024.0 + 0.5);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_positive();
    t_mirror();
    t_saturate();
    t_negative();
    t_rectify();
    t_silent();
    t_feedback();
    t_hold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule